// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two IEEE-754 binary32 operands in a single clocked step. A caller presents both operands, a 3-bit operation code and a 2-bit rounding selector, and raises `start` for one cycle. When the code selects multiplication, the product and five exception flags are registered on that edge, and `done` pulses high for the following cycle. The result and flags then hold until the next accepted request.

The datapath takes the sign as the XOR of the operand signs. It adds the biased exponents and removes the bias. It multiplies the two 24-bit significands, with their hidden bits, into a 48-bit product, then normalizes and rounds under the selected mode. After rounding, the block normalizes again and checks the exponent range a second time. Zero, infinity and NaN operands are screened before the arithmetic. An operand whose exponent field is zero counts as zero. Results too small for the normal range are flushed to a signed zero.

Top module: `fmul_sp`

## Requirements
- R1: A request is accepted only when `start` is high and `op` equals 3'b010. `done` is then high in exactly the next cycle and `product`/flags carry that request's result. Any other `op` value, or `start` low, leaves `done` low and keeps `product` and all flags unchanged.
- R2: The sign bit (bit 31) of a numeric result is the XOR of the operand sign bits. For example, 0x40A00000 (5.0) times 0x40000000 (2.0) gives 0x41200000 (10.0), and the same product with one sign bit set gives 0xC1200000.
- R3: For normal operands, the result exponent is the sum of the 8-bit exponent fields (bits 30:23) minus 127. The result significand is the 48-bit product of the two significands with the hidden bit restored. When product bit 47 is set, the significand is taken one position higher and the exponent is incremented.
- R4: `rmode` selects the rounding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward zero, 2'b10 rounds toward +infinity, and 2'b11 rounds toward -infinity.
- R5: If rounding carries out of the 24-bit significand, the significand becomes 1.0, the exponent increases by one, and the overflow test uses the incremented exponent.
- R6: If the final exponent is 255 or more, `flag_overflow` and `flag_inexact` are set. The result is signed infinity (exponent 0xFF, fraction 0) under modes 00, under 10 for a positive result, and under 11 for a negative result. Otherwise the result is the signed largest finite value (exponent 0xFE, fraction all ones).
- R7: If the final exponent is 0 or less, the result is a zero carrying the computed sign, and `flag_underflow` and `flag_inexact` are set.
- R8: `flag_inexact` is set for an in-range result exactly when at least one product bit discarded below the kept significand is nonzero.
- R9: An operand with exponent field 0 counts as zero, including a nonzero fraction. A zero operand times any finite value gives the signed zero with all flags clear. Infinity times a nonzero non-NaN gives signed infinity with all flags clear.
- R10: Any NaN operand (exponent 0xFF, nonzero fraction) gives 0x7FC00000. Zero times infinity also gives 0x7FC00000 and sets `flag_invalid`. `flag_invalid` is set in no other case.
- R11: `flag_divzero` is always 0.
- R12: While `rst_n` is low, `done`, `product` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe |
| op | input | 3 | Operation code; 3'b010 is multiply |
| rmode | input | 2 | Rounding mode selector |
| a | input | 32 | First binary32 operand |
| b | input | 32 | Second binary32 operand |
| done | output | 1 | One-cycle completion strobe |
| product | output | 32 | Registered binary32 result |
| flag_invalid | output | 1 | Invalid operation |
| flag_divzero | output | 1 | Division by zero (always 0) |
| flag_overflow | output | 1 | Exponent overflow |
| flag_underflow | output | 1 | Result flushed to zero |
| flag_inexact | output | 1 | Rounded result differs from exact |

## Verification
The sweep mixes fraction patterns with exponents at the range edges. Exponent pairs summing to 126/127 land on the flush boundary, where rounding or the bit-47 shift moves the result across it; a design that tested the exponent before rounding would return a tiny normal instead of zero, or the reverse. The pair 0x3FAAAAAB × 0x3FBFFFFF has a product just below 2.0 with only sticky bits set, so rounding up must produce exactly 0x40000000; a design lacking the second normalization would instead output 0x3F800000 at half the value. Overflow pairs near exponent 254 catch a wrong choice between infinity and the largest finite value under the directed modes. Zero-times-infinity, NaN, subnormal and rejected-opcode cases catch a missing screen, an absent invalid flag, or a result that changes without a valid request.

// File: rtl/fmul_sp.sv
module fmul_sp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [1:0]  rmode,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic        done,
  output logic [31:0] product,
  output logic        flag_invalid,
  output logic        flag_divzero,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact
);
  localparam logic [2:0]  OP_MUL = 3'b010;
  localparam logic [31:0] QNAN   = 32'h7FC0_0000;
  localparam logic [1:0]  RM_NE  = 2'b00;
  localparam logic [1:0]  RM_TZ  = 2'b01;
  localparam logic [1:0]  RM_UP  = 2'b10;
  localparam logic [1:0]  RM_DN  = 2'b11;

  logic [7:0]  ea, eb;
  logic [22:0] fa, fb;
  logic        sgn;
  logic        a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;

  assign ea  = a[30:23];
  assign eb  = b[30:23];
  assign fa  = a[22:0];
  assign fb  = b[22:0];
  assign sgn = a[31] ^ b[31];

  assign a_zero = (ea == 8'd0);
  assign b_zero = (eb == 8'd0);
  assign a_inf  = (ea == 8'hFF) && (fa == 23'd0);
  assign b_inf  = (eb == 8'hFF) && (fb == 23'd0);
  assign a_nan  = (ea == 8'hFF) && (fa != 23'd0);
  assign b_nan  = (eb == 8'hFF) && (fb != 23'd0);

  logic [47:0] prod;
  logic        hi;
  logic [23:0] sig;
  logic        grd, stk, lost;

  assign prod = {24'd0, 1'b1, fa} * {24'd0, 1'b1, fb};
  assign hi   = prod[47];
  assign sig  = hi ? prod[47:24] : prod[46:23];
  assign grd  = hi ? prod[23] : prod[22];
  assign stk  = hi ? (|prod[22:0]) : (|prod[21:0]);
  assign lost = grd | stk;

  logic inc;
  always_comb begin
    case (rmode)
      RM_NE:   inc = grd & (stk | sig[0]);
      RM_TZ:   inc = 1'b0;
      RM_UP:   inc = lost & ~sgn;
      default: inc = lost & sgn;
    endcase
  end

  logic [24:0] rsum;
  logic        carry;
  logic [22:0] frac_r;
  logic [9:0]  e_sum, e_n, e_r;
  logic        ovf, unf, sat_max;

  assign rsum   = {1'b0, sig} + {24'd0, inc};
  assign carry  = rsum[24];
  assign frac_r = carry ? rsum[23:1] : rsum[22:0];

  assign e_sum = {2'b00, ea} + {2'b00, eb} - 10'd127;
  assign e_n   = e_sum + {9'd0, hi};
  assign e_r   = e_n + {9'd0, carry};
  assign ovf   = $signed(e_r) > $signed(10'sd254);
  assign unf   = $signed(e_r) < $signed(10'sd1);

  assign sat_max = (rmode == RM_TZ) || (rmode == RM_UP && sgn) || (rmode == RM_DN && !sgn);

  logic [31:0] r_res;
  logic        r_inv, r_ovf, r_unf, r_ix;

  always_comb begin
    r_res = {sgn, e_r[7:0], frac_r};
    r_inv = 1'b0;
    r_ovf = 1'b0;
    r_unf = 1'b0;
    r_ix  = lost;
    if (a_nan || b_nan) begin
      r_res = QNAN;
      r_ix  = 1'b0;
    end else if ((a_zero && b_inf) || (a_inf && b_zero)) begin
      r_res = QNAN;
      r_inv = 1'b1;
      r_ix  = 1'b0;
    end else if (a_inf || b_inf) begin
      r_res = {sgn, 8'hFF, 23'd0};
      r_ix  = 1'b0;
    end else if (a_zero || b_zero) begin
      r_res = {sgn, 31'd0};
      r_ix  = 1'b0;
    end else if (ovf) begin
      r_res = sat_max ? {sgn, 8'hFE, 23'h7F_FFFF} : {sgn, 8'hFF, 23'd0};
      r_ovf = 1'b1;
      r_ix  = 1'b1;
    end else if (unf) begin
      r_res = {sgn, 31'd0};
      r_unf = 1'b1;
      r_ix  = 1'b1;
    end
  end

  logic take;
  assign take         = start && (op == OP_MUL);
  assign flag_divzero = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done           <= 1'b0;
      product        <= 32'd0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      flag_inexact   <= 1'b0;
    end else begin
      done <= take;
      if (take) begin
        product        <= r_res;
        flag_invalid   <= r_inv;
        flag_overflow  <= r_ovf;
        flag_underflow <= r_unf;
        flag_inexact   <= r_ix;
      end
    end
  end
endmodule

// File: rtl/fmul_sp_props.sv
module fmul_sp_props (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  op,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic        done,
  input logic [31:0] product,
  input logic        flag_invalid,
  input logic        flag_overflow,
  input logic        flag_underflow,
  input logic        flag_inexact
);
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'b010) |=> done);

  assert_done_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start && op == 3'b010));

  assert_hold_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && op == 3'b010) |=> ($stable(product) && $stable(flag_inexact) && $stable(flag_invalid)));

  assert_sign_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && product != 32'h7FC0_0000) |-> (product[31] == ($past(a[31]) ^ $past(b[31]))));

  assert_ovf_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> flag_inexact);

  assert_unf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> (product[30:0] == 31'd0 && flag_inexact));

  assert_invalid_qnan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (product == 32'h7FC0_0000));
endmodule

bind fmul_sp fmul_sp_props u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
  .done(done), .product(product), .flag_invalid(flag_invalid),
  .flag_overflow(flag_overflow), .flag_underflow(flag_underflow),
  .flag_inexact(flag_inexact)
);

// File: tb/fmul_sp_bench.sv
module fmul_sp_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'b010;
  logic [1:0]  rmode = 2'b00;
  logic [31:0] a = 32'd0, b = 32'd0;
  logic        done, f_inv, f_dz, f_ovf, f_unf, f_ix;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmul_sp u_fmul_sp (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rmode(rmode),
    .a(a), .b(b), .done(done), .product(product),
    .flag_invalid(f_inv), .flag_divzero(f_dz), .flag_overflow(f_ovf),
    .flag_underflow(f_unf), .flag_inexact(f_ix)
  );

  function automatic real as_real(input logic [31:0] x);
    logic [10:0] e11;
    e11 = {3'b000, x[30:23]} + 11'd896;
    return $bitstoreal({x[31], e11, x[22:0], 29'd0});
  endfunction

  // {invalid, divzero, overflow, underflow, inexact, result}
  function automatic logic [36:0] model(input logic [31:0] x, input logic [31:0] y, input logic [1:0] m);
    logic s, zx, zy, ix_, iy, nx, ny, inex, up;
    logic [63:0] bits;
    logic [24:0] top;
    logic [28:0] rem;
    int e;
    s  = x[31] ^ y[31];
    zx = x[30:23] == 0;  zy = y[30:23] == 0;
    ix_ = x[30:23] == 8'hFF && x[22:0] == 0;
    iy  = y[30:23] == 8'hFF && y[22:0] == 0;
    nx = x[30:23] == 8'hFF && x[22:0] != 0;
    ny = y[30:23] == 8'hFF && y[22:0] != 0;
    if (nx || ny) return {5'b00000, QNAN};
    if ((zx && iy) || (ix_ && zy)) return {5'b10000, QNAN};
    if (ix_ || iy) return {5'b00000, s, 8'hFF, 23'd0};
    if (zx || zy) return {5'b00000, s, 31'd0};
    bits = $realtobits(as_real(x) * as_real(y));
    e    = int'(bits[62:52]) - 896;
    top  = {1'b0, 1'b1, bits[51:29]};
    rem  = bits[28:0];
    inex = rem != 0;
    case (m)
      2'b00: up = (rem > 29'h1000_0000) || (rem == 29'h1000_0000 && top[0]);
      2'b01: up = 1'b0;
      2'b10: up = inex && !s;
      default: up = inex && s;
    endcase
    top = top + {24'd0, up};
    if (top[24]) begin
      top = top >> 1;
      e = e + 1;
    end
    if (e >= 255) begin
      if (m == 2'b01 || (m == 2'b10 && s) || (m == 2'b11 && !s))
        return {5'b00101, s, 8'hFE, 23'h7F_FFFF};
      return {5'b00101, s, 8'hFF, 23'd0};
    end
    if (e <= 0) return {5'b00011, s, 31'd0};
    return {4'b0000, inex, s, e[7:0], top[22:0]};
  endfunction

  function automatic logic [36:0] observed();
    return {f_inv, f_dz, f_ovf, f_unf, f_ix, product};
  endfunction

  task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got flags=%b res=%h, expected flags=%b res=%h",
               req, got[36:32], got[31:0], exp[36:32], exp[31:0]);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [1:0] m, input string req);
    logic [36:0] exp;
    exp = model(x, y, m);
    @(negedge clk);
    a = x; b = y; rmode = m; op = 3'b010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " done"}, {36'd0, done}, 37'd1);
    check(req, observed(), exp);
  endtask

  task automatic run_lit(input logic [31:0] x, input logic [31:0] y, input logic [1:0] m,
                         input logic [36:0] exp, input string req);
    @(negedge clk);
    a = x; b = y; rmode = m; op = 3'b010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, observed(), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1: watchdog expired, got hang, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [22:0] fr [8];
    logic [7:0]  ex_a [6];
    logic [7:0]  ex_b [4];
    logic [36:0] held;
    fr   = '{23'h000000, 23'h000001, 23'h7FFFFF, 23'h400000,
             23'h3FFFFF, 23'h555555, 23'h2AAAAA, 23'h0F0F0F};
    ex_a = '{8'd1, 8'd2, 8'd64, 8'd127, 8'd200, 8'd254};
    ex_b = '{8'd1, 8'd126, 8'd127, 8'd253};

    repeat (3) @(negedge clk);
    check("R12 reset", {done, observed()}, 38'd0);
    rst_n = 1'b1;

    // R2, R3: directed values
    run_lit(32'h40A00000, 32'h40000000, 2'b00, {5'b0, 32'h41200000}, "R2 5*2");
    run_lit(32'hC0A00000, 32'h40000000, 2'b00, {5'b0, 32'hC1200000}, "R2 -5*2");
    run_lit(32'h40400000, 32'h40400000, 2'b00, {5'b0, 32'h41100000}, "R3 3*3 shift");
    // R5: carry out of rounding just below 2.0
    run_lit(32'h3FAAAAAB, 32'h3FBFFFFF, 2'b10, {5'b00001, 32'h40000000}, "R5 carry up");
    run_lit(32'h3FAAAAAB, 32'h3FBFFFFF, 2'b01, {5'b00001, 32'h3FFFFFFF}, "R5 no carry tz");
    // R6 overflow per mode
    run_lit(32'h7F000000, 32'h40000000, 2'b00, {5'b00101, 32'h7F800000}, "R6 ne inf");
    run_lit(32'h7F000000, 32'h40000000, 2'b01, {5'b00101, 32'h7F7FFFFF}, "R6 tz max");
    run_lit(32'hFF000000, 32'h40000000, 2'b10, {5'b00101, 32'hFF7FFFFF}, "R6 up neg max");
    // R7 underflow
    run_lit(32'h00800000, 32'hBF000000, 2'b00, {5'b00011, 32'h80000000}, "R7 flush");
    // R9 zero, subnormal, infinity
    run_lit(32'h00000000, 32'hC0A00000, 2'b00, {5'b0, 32'h80000000}, "R9 zero");
    run_lit(32'h00012345, 32'h40A00000, 2'b00, {5'b0, 32'h00000000}, "R9 subnormal");
    run_lit(32'h7F800000, 32'hC0000000, 2'b00, {5'b0, 32'hFF800000}, "R9 inf");
    // R10 invalid and NaN
    run_lit(32'h7F800000, 32'h00000000, 2'b00, {5'b10000, QNAN}, "R10 zero*inf");
    run_lit(32'h7FA00001, 32'h40000000, 2'b00, {5'b00000, QNAN}, "R10 nan");
    run_lit(32'h3F800001, 32'h3F800001, 2'b00, {5'b00001, 32'h3F800002}, "R8 inexact");

    // R1: other op codes ignored
    run_lit(32'h40A00000, 32'h40000000, 2'b00, {5'b0, 32'h41200000}, "R1 base");
    held = observed();
    for (int k = 0; k < 8; k++) begin
      if (k == 2) continue;
      @(negedge clk);
      a = 32'h7F800000; b = 32'h00000000; op = 3'(k); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R1 ignored done", {36'd0, done}, 37'd0);
      check("R1 ignored hold", observed(), held);
    end
    op = 3'b010;

    // R3, R4, R6, R7, R8, R11: sweep
    for (int ai = 0; ai < 48; ai++)
      for (int bi = 0; bi < 32; bi++)
        for (int sb = 0; sb < 2; sb++)
          for (int m = 0; m < 4; m++) begin
            logic [31:0] x, y;
            logic [36:0] e;
            x = {1'b0, ex_a[ai / 8], fr[ai % 8]};
            y = {sb[0], ex_b[bi / 8], fr[bi % 8]};
            e = model(x, y, 2'(m));
            if (e[34])      run(x, y, 2'(m), "R6 sweep");
            else if (e[33]) run(x, y, 2'(m), "R7 sweep");
            else            run(x, y, 2'(m), "R4 sweep");
            if (f_dz !== 1'b0) begin
              errors++;
              $display("FAIL R11: got divzero=%b expected 0", f_dz);
            end
          end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule